// File: doc/BRIEF.md
# Stack Pointer Register Unit

This block holds the stack pointer of a small 8-bit processor core. Software sees the pointer as two byte-wide registers on the core's I/O register bus. The high byte sits one address above the low byte. Only the low 12 bits are real storage. The upper four bits always read as zero.

The core's control logic moves the pointer with four one-hot strobes:

- A single data byte push lowers the pointer by one.
- A single data byte pop raises it by one.
- Saving a return address, on a call or on interrupt entry, lowers it by two.
- Restoring a return address, on a return from subroutine or from interrupt, raises it by two.

The block also gives the data memory the address for the access of the current cycle. A push writes at the current pointer and then decrements it. A pop increments first and then reads, so the address it presents is the pointer plus one.

Software is expected to place the stack above address 0x60 before it uses calls or interrupts. The hardware does not check this. All arithmetic wraps within the 12 implemented bits.

Top module: `stack_ptr_unit`

## Requirements
- R1: While `rst_n` is low, and after reset is released, the pointer value is 0x0000.
- R2: A bus write at I/O address 0x3D loads bits 7:0 of the pointer. Address 0x3E loads the higher bits. A bus read returns bits 7:0 at 0x3D and bits 15:8 at 0x3E, on the same cycle as the address (combinational).
- R3: Bits 15:12 of the pointer always read as zero. Writes to bits 7:4 of the high byte have no effect.
- R4: With `push_byte` high, the pointer is one less on the next cycle. With `pop_byte` high, it is one more.
- R5: With `push_ret` high, the pointer is two less on the next cycle. With `pop_ret` high, it is two more. At most one of the four strobes is high in any cycle.
- R6: `mem_addr` equals the pointer when `pop_byte` and `pop_ret` are low. When either is high, it equals the pointer plus one (modulo 4096).
- R7: The pointer arithmetic wraps modulo 4096. For example, 0x000 minus 2 gives 0xFFE, and 0xFFF plus 1 gives 0x000.
- R8: A bus write to either byte in the same cycle as a strobe takes effect, and the strobe is ignored for that cycle.
- R9: Reads at any other I/O address return 0x00. Writes there leave the pointer unchanged.
- R10: With no strobe and no matching write, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | I/O write enable |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| push_byte | input | 1 | Data byte push strobe |
| pop_byte | input | 1 | Data byte pop strobe |
| push_ret | input | 1 | Return address push strobe |
| pop_ret | input | 1 | Return address pop strobe |
| mem_addr | output | 16 | Data memory address for this cycle's stack access |
| sp | output | 16 | Current pointer value |

## Verification
The assertions check three things on every cycle:

- Each strobe moves the pointer by its step.
- A byte write lands exactly as written and wins over any strobe.
- An idle cycle keeps the pointer, and the strobes never overlap.

Some behaviours only the bench's scenarios can show. These are the byte-lane read values and the zero upper bits seen through the bus. They also include the memory address presented for pops, wrap-around at both ends of the 12-bit range, and the silence of unmapped addresses.

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int IMPL_W = 12,
  parameter int IO_AW = 6,
  parameter logic [IO_AW-1:0] LO_ADDR = 6'h3D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic             push_byte,
  input  logic             pop_byte,
  input  logic             push_ret,
  input  logic             pop_ret,
  output logic [15:0]      mem_addr,
  output logic [15:0]      sp
);
  localparam logic [IO_AW-1:0] HI_ADDR = LO_ADDR + 1'b1;
  localparam int HI_BITS = IMPL_W - 8;
  localparam logic [IMPL_W-1:0] ONE = IMPL_W'(1);
  localparam logic [IMPL_W-1:0] TWO = IMPL_W'(2);

  logic [IMPL_W-1:0] sp_q, sp_nxt, sp_inc;
  logic wr_lo, wr_hi;

  assign wr_lo  = io_wr && (io_addr == LO_ADDR);
  assign wr_hi  = io_wr && (io_addr == HI_ADDR);
  assign sp_inc = sp_q + ONE;

  always_comb begin
    sp_nxt = sp_q;
    if (wr_lo)          sp_nxt[7:0] = io_wdata;
    else if (wr_hi)     sp_nxt[IMPL_W-1:8] = io_wdata[HI_BITS-1:0];
    else if (push_byte) sp_nxt = sp_q - ONE;
    else if (pop_byte)  sp_nxt = sp_inc;
    else if (push_ret)  sp_nxt = sp_q - TWO;
    else if (pop_ret)   sp_nxt = sp_q + TWO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_nxt;
  end

  assign sp       = {{(16-IMPL_W){1'b0}}, sp_q};
  assign mem_addr = (pop_byte || pop_ret) ? {{(16-IMPL_W){1'b0}}, sp_inc} : sp;

  always_comb begin
    if (io_addr == LO_ADDR)      io_rdata = sp_q[7:0];
    else if (io_addr == HI_ADDR) io_rdata = {{(8-HI_BITS){1'b0}}, sp_q[IMPL_W-1:8]};
    else                         io_rdata = 8'h00;
  end

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_byte, pop_byte, push_ret, pop_ret}));

  a_r4_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (push_byte && !io_wr) |=> sp_q == $past(sp_q) - ONE);

  a_r4_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_byte && !io_wr) |=> sp_q == $past(sp_q) + ONE);

  a_r5_call_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ret && !io_wr) |=> sp_q == $past(sp_q) - TWO);

  a_r5_ret_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ret && !io_wr) |=> sp_q == $past(sp_q) + TWO);

  a_r8_lo_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> sp_q[7:0] == $past(io_wdata));

  a_r3_hi_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> sp_q[IMPL_W-1:8] == $past(io_wdata[HI_BITS-1:0]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi || push_byte || pop_byte || push_ret || pop_ret) |=> $stable(sp_q));
endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] LO = 6'h3D;
  localparam logic [5:0] HI = 6'h3E;

  logic clk = 0, rst_n = 0;
  logic [5:0] io_addr = '0;
  logic io_wr = 0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic push_byte = 0, pop_byte = 0, push_ret = 0, pop_ret = 0;
  logic [15:0] mem_addr, sp;

  int checks = 0, errors = 0;
  logic [11:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_ptr_unit i_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .push_byte(push_byte),
    .pop_byte(pop_byte), .push_ret(push_ret), .pop_ret(pop_ret),
    .mem_addr(mem_addr), .sp(sp));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] model_next(input logic [11:0] cur, input logic wr,
      input logic [5:0] a, input logic [7:0] d, input int code);
    logic [11:0] n = cur;
    if (wr && a == LO)      n[7:0] = d;
    else if (wr && a == HI) n[11:8] = d[3:0];
    else if (code == 1)     n = cur - 12'd1;
    else if (code == 2)     n = cur + 12'd1;
    else if (code == 3)     n = cur - 12'd2;
    else if (code == 4)     n = cur + 12'd2;
    return n;
  endfunction

  // code: 0 none, 1 push_byte, 2 pop_byte, 3 push_ret, 4 pop_ret
  task automatic step(input logic wr, input logic [5:0] a, input logic [7:0] d, input int code);
    logic [11:0] ea;
    io_wr = wr; io_addr = a; io_wdata = d;
    push_byte = (code == 1); pop_byte = (code == 2);
    push_ret = (code == 3); pop_ret = (code == 4);
    #1;
    ea = (code == 2 || code == 4) ? model + 12'd1 : model;
    chk("R6 mem_addr", mem_addr, {4'h0, ea});
    @(posedge clk); @(negedge clk);
    model = model_next(model, wr, a, d, code);
    io_wr = 0; push_byte = 0; pop_byte = 0; push_ret = 0; pop_ret = 0;
    chk(code != 0 && wr ? "R8 write wins" : "R4/R5/R10 pointer", sp, {4'h0, model});
  endtask

  task automatic read_both();
    io_addr = LO; #1;
    chk("R2 low read", {8'h0, io_rdata}, {8'h0, model[7:0]});
    io_addr = HI; #1;
    chk("R3 high read", {8'h0, io_rdata}, {12'h0, model[11:8]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    chk("R1 reset", sp, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", sp, 16'h0000);
    read_both();
    // R7 wrap down and up
    step(0, LO, 0, 3); chk("R7 wrap down", sp, 16'h0FFE);
    step(0, LO, 0, 2); step(0, LO, 0, 4); chk("R7 wrap up", sp, 16'h0001);
    // R2/R3 byte writes, upper nibble masked
    step(1, HI, 8'hF8, 0); step(1, LO, 8'h5F, 0);
    chk("R3 masked high", sp, 16'h085F);
    read_both();
    // R8 write with strobe
    step(1, LO, 8'hA0, 1); chk("R8 low write wins", sp, 16'h08A0);
    step(1, HI, 8'h02, 4); chk("R8 high write wins", sp, 16'h02A0);
    // R9 other addresses
    step(1, 6'h3F, 8'hFF, 0); chk("R9 unmapped write", sp, 16'h02A0);
    io_addr = 6'h3C; #1; chk("R9 unmapped read", {8'h0, io_rdata}, 16'h0000);
    // R6 pop address at wrap
    step(1, HI, 8'h0F, 0); step(1, LO, 8'hFF, 0);
    step(0, LO, 0, 4); chk("R7 ret wrap", sp, 16'h0001);
    for (int i = 0; i < 400; i++) begin
      int code = int'($urandom_range(0, 4));
      int r = int'($urandom_range(0, 9));
      logic [5:0] a = (r < 2) ? LO : (r < 4) ? HI : (r < 5) ? 6'($urandom_range(0, 63)) : LO;
      step(r < 5, a, 8'($urandom), code);
      if (i % 16 == 0) read_both();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule